// File: doc/BRIEF.md
# Blank Sector Zero-Bit Tally

This block watches the bytes of one flash sector as they stream past and decides whether the sector is still blank. A sector is a data area (512 bytes in normal use) followed by its stored check code (13 bytes in normal use). Each byte carries a region tag that says which of the two it belongs to. For every accepted byte the block counts the bits that are zero and adds that number to the tally of the byte's region. A tally stops growing once it passes the configured limit (8 by default), so each tally needs only a few bits.

The verdict is registered with the last byte of the sector. If the two tallies together are at most the limit, the sector is blank: any zero bits are treated as bit flips on an erased page. In that case, when the data tally is nonzero, the block raises a request to overwrite the data area with all ones and reports the data tally as the number of bits corrected. The overwrite itself is done elsewhere. If the sum is above the limit, the block reports an uncorrectable sector instead. A check-code byte that arrives before the data, or a data byte that follows check-code bytes, sets an ordering error for that sector.

Top module: `erased_sector_tally`

## Requirements
- R1: For each accepted byte tagged data (`in_ecc`=0), the data tally grows by the number of zero bits in that byte. The new value appears on `data_zeros` one clock after the byte is accepted.
- R2: For each accepted byte tagged check code (`in_ecc`=1), the check-code tally grows by the number of zero bits in that byte. The new value appears on `ecc_zeros` one clock after the byte is accepted.
- R3: Each tally saturates at LIMIT+1 and never goes higher.
- R4: `done` is high for exactly the one clock that follows the acceptance of a byte with `in_last`=1, and is low otherwise.
- R5: With `done`, `erased` is 1 exactly when `data_zeros + ecc_zeros` is at most LIMIT.
- R6: With `done`, `uncorrectable` is 1 exactly when `data_zeros + ecc_zeros` exceeds LIMIT. It is never high together with `erased`.
- R7: With `done`, `fill_req` is 1 exactly when the sector is erased and the data tally is nonzero. `fixed_bits` then equals the data tally, and it is 0 when the sector is not erased.
- R8: A byte presented while `in_valid` is 0 changes no tally, verdict or ordering flag, whatever its value, tag or `in_last`.
- R9: The first accepted byte after a sector's last byte starts a new sector. Both tallies restart from that byte alone, and a verdict from the previous sector is cleared unless this byte is itself the last.
- R10: `order_err` is 1 from the byte that causes it until the next sector starts, when either the sector's first byte is tagged check code or a data byte follows a check-code byte in the same sector.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_byte | input | BYTE_W | Sector byte |
| in_ecc | input | 1 | Region tag: 0 data, 1 stored check code |
| in_last | input | 1 | Final byte of the sector |
| data_zeros | output | $clog2(LIMIT+2) | Saturating zero-bit tally of the data region |
| ecc_zeros | output | $clog2(LIMIT+2) | Saturating zero-bit tally of the check-code region |
| done | output | 1 | One-cycle strobe after the sector's last byte |
| erased | output | 1 | Sector judged blank |
| uncorrectable | output | 1 | Too many zero bits for a blank sector |
| fill_req | output | 1 | Data area must be overwritten with all ones |
| fixed_bits | output | $clog2(LIMIT+2) | Bits reported as corrected on a blank sector |
| order_err | output | 1 | Region tags arrived out of order in this sector |

## Verification
The bench builds the block with LIMIT set to 3 and 8-bit bytes. With that limit, saturation and the boundary between blank and uncorrectable sectors are reached with only a handful of single-zero bytes. This makes it cheap to sweep every data-tally and check-code-tally combination from 0 to 5 on both sides of the boundary. Every one of the 256 byte values is sent once in each region, so the zero count of every pattern is compared against an arithmetic popcount. Sequences of idle bytes and misordered tags are also sent.

// File: rtl/erz_pkg.sv
package erz_pkg;

  typedef enum logic {
    REGION_DATA = 1'b0,
    REGION_CODE = 1'b1
  } region_e;

  typedef struct packed {
    logic blank;
    logic bad;
    logic fill;
  } verdict_t;

endpackage

// File: rtl/erz_zero_count.sv
module erz_zero_count #(
  parameter int BYTE_W = 8,
  localparam int ZW = $clog2(BYTE_W + 1)
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ZW-1:0]     zeros_o
);

  logic [BYTE_W-1:0] inv;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_inv
    assign inv[g] = ~byte_i[g];
  end

  always_comb begin
    zeros_o = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      zeros_o = zeros_o + ZW'(inv[i]);
    end
  end

endmodule

// File: rtl/erz_sat_tally.sv
module erz_sat_tally #(
  parameter int LIMIT = 8,
  parameter int ZW    = 4,
  localparam int CW   = $clog2(LIMIT + 2),
  localparam int AW   = ((CW > ZW) ? CW : ZW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          restart,
  input  logic [ZW-1:0] add_val,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] next_o
);

  localparam logic [AW-1:0] LIM_A = AW'(LIMIT);
  localparam logic [CW-1:0] TOP_C = CW'(LIMIT + 1);

  logic [CW-1:0] base;
  logic [AW-1:0] sum;

  always_comb begin
    base = restart ? '0 : count_o;
    sum  = AW'(base) + AW'(add_val);
    next_o = (sum > LIM_A) ? TOP_C : sum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
    end else if (en) begin
      count_o <= next_o;
    end
  end

  AST_TALLY_CAP: assert property (@(posedge clk) disable iff (rst)
    count_o <= TOP_C); // R3

  AST_TALLY_MONO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && !$past(restart)) |-> (count_o >= $past(count_o))); // R3

endmodule

// File: rtl/erased_sector_tally.sv
module erased_sector_tally #(
  parameter int BYTE_W = 8,
  parameter int LIMIT  = 8,
  localparam int ZW    = $clog2(BYTE_W + 1),
  localparam int CW    = $clog2(LIMIT + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_ecc,
  input  logic              in_last,
  output logic [CW-1:0]     data_zeros,
  output logic [CW-1:0]     ecc_zeros,
  output logic              done,
  output logic              erased,
  output logic              uncorrectable,
  output logic              fill_req,
  output logic [CW-1:0]     fixed_bits,
  output logic              order_err
);

  import erz_pkg::*;

  localparam logic [CW:0] LIM_S = (CW + 1)'(LIMIT);

  region_e       region;
  logic [ZW-1:0] byte_zeros;
  logic [ZW-1:0] data_add;
  logic [ZW-1:0] code_add;
  logic [CW-1:0] data_next;
  logic [CW-1:0] code_next;
  logic [CW:0]   total_next;
  logic          first_q;
  logic          seen_code_q;
  verdict_t      verdict_next;
  verdict_t      verdict_q;

  assign region = region_e'(in_ecc);

  erz_zero_count #(.BYTE_W(BYTE_W)) u_zeros (
    .byte_i  (in_byte),
    .zeros_o (byte_zeros)
  );

  assign data_add = (region == REGION_DATA) ? byte_zeros : '0;
  assign code_add = (region == REGION_CODE) ? byte_zeros : '0;

  erz_sat_tally #(.LIMIT(LIMIT), .ZW(ZW)) u_data_tally (
    .clk     (clk),
    .rst     (rst),
    .en      (in_valid),
    .restart (first_q),
    .add_val (data_add),
    .count_o (data_zeros),
    .next_o  (data_next)
  );

  erz_sat_tally #(.LIMIT(LIMIT), .ZW(ZW)) u_code_tally (
    .clk     (clk),
    .rst     (rst),
    .en      (in_valid),
    .restart (first_q),
    .add_val (code_add),
    .count_o (ecc_zeros),
    .next_o  (code_next)
  );

  always_comb begin
    total_next         = {1'b0, data_next} + {1'b0, code_next};
    verdict_next.blank = (total_next <= LIM_S);
    verdict_next.bad   = !verdict_next.blank;
    verdict_next.fill  = verdict_next.blank && (data_next != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q     <= 1'b1;
      seen_code_q <= 1'b0;
      order_err   <= 1'b0;
      done        <= 1'b0;
      verdict_q   <= '0;
      fixed_bits  <= '0;
    end else begin
      done <= in_valid && in_last;
      if (in_valid) begin
        first_q <= in_last;
        if (first_q) begin
          seen_code_q <= (region == REGION_CODE);
          order_err   <= (region == REGION_CODE);
        end else begin
          seen_code_q <= seen_code_q || (region == REGION_CODE);
          order_err   <= order_err || (seen_code_q && (region == REGION_DATA));
        end
        if (in_last) begin
          verdict_q  <= verdict_next;
          fixed_bits <= verdict_next.blank ? data_next : '0;
        end else if (first_q) begin
          verdict_q  <= '0;
          fixed_bits <= '0;
        end
      end
    end
  end

  assign erased        = verdict_q.blank;
  assign uncorrectable = verdict_q.bad;
  assign fill_req      = verdict_q.fill;

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(erased && uncorrectable)); // R6

  AST_FILL_NEEDS_BLANK: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> (erased && (fixed_bits == data_zeros) && (data_zeros != '0))); // R7

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && done) |-> $past(in_valid && in_last)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |->
      ($stable(data_zeros) && $stable(ecc_zeros) && $stable(order_err) && $stable(erased))); // R8

  AST_ORDER_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !first_q && seen_code_q && (region == REGION_DATA)) |=> order_err); // R10

endmodule

// File: tb/test_erased_sector_tally.sv
`timescale 1ns/1ps
module test_erased_sector_tally;

  localparam int BW  = 8;
  localparam int LIM = 3;
  localparam int CW  = $clog2(LIM + 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [BW-1:0] in_byte = '0;
  logic          in_ecc = 1'b0;
  logic          in_last = 1'b0;
  logic [CW-1:0] data_zeros;
  logic [CW-1:0] ecc_zeros;
  logic          done;
  logic          erased;
  logic          uncorrectable;
  logic          fill_req;
  logic [CW-1:0] fixed_bits;
  logic          order_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  erased_sector_tally #(.BYTE_W(BW), .LIMIT(LIM)) i_erased_sector_tally (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ecc(in_ecc), .in_last(in_last), .data_zeros(data_zeros),
    .ecc_zeros(ecc_zeros), .done(done), .erased(erased),
    .uncorrectable(uncorrectable), .fill_req(fill_req),
    .fixed_bits(fixed_bits), .order_err(order_err)
  );

  function automatic int zcount(input int v);
    int n = 0;
    for (int i = 0; i < BW; i++) if (((v >> i) & 1) == 0) n++;
    return n;
  endfunction

  function automatic int sat(input int x);
    return (x > LIM) ? LIM + 1 : x;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one accepted byte at a falling edge; return at the next falling edge
  task automatic put(input int b, input bit ecc, input bit last);
    in_valid = 1'b1; in_byte = BW'(b); in_ecc = ecc; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_byte = '0; in_ecc = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; in_byte = BW'(8'h00); in_ecc = 1'b0; in_last = 1'b1;
      @(negedge clk);
    end
    in_last = 1'b0;
  endtask

  task automatic verdict(input string tag, input int dz, input int ez);
    int sum = dz + ez;
    bit blank = (sum <= LIM);
    check({tag, " R4 done"}, done, 1);
    check({tag, " R1 data tally"}, data_zeros, dz);
    check({tag, " R2 code tally"}, ecc_zeros, ez);
    check({tag, " R5 erased"}, erased, blank);
    check({tag, " R6 uncorrectable"}, uncorrectable, !blank);
    check({tag, " R7 fill"}, fill_req, blank && dz != 0);
    check({tag, " R7 fixed"}, fixed_bits, blank ? dz : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 data", data_zeros, 0);
    check("R11 code", ecc_zeros, 0);
    check("R11 flags", {done, erased, uncorrectable, fill_req, order_err}, 0);
    check("R11 fixed", fixed_bits, 0);

    // every byte value in the data region
    for (int v = 0; v < 256; v++) begin
      put(v, 1'b0, 1'b0);
      check("R9 R1 first byte data tally", data_zeros, sat(zcount(v)));
      check("R9 verdict cleared", erased | uncorrectable, 0);
      put(8'hFF, 1'b1, 1'b1);
      verdict("sweepD", sat(zcount(v)), 0);
      check("R10 in order", order_err, 0);
      @(negedge clk);
      check("R4 done low", done, 0);
    end

    // every byte value in the check-code region
    for (int v = 0; v < 256; v++) begin
      put(8'hFF, 1'b0, 1'b0);
      put(v, 1'b1, 1'b1);
      verdict("sweepE", 0, sat(zcount(v)));
    end

    // tally combinations across the blank boundary, with idle gaps
    for (int a = 0; a <= 5; a++) begin
      for (int b = 0; b <= 5; b++) begin
        put(8'hFF, 1'b0, 1'b0);
        idle(3);
        check("R8 idle data", data_zeros, 0);
        check("R8 idle done", done, 0);
        for (int k = 0; k < a; k++) begin
          put(8'hFE, 1'b0, 1'b0);
          check("R3 data saturation", data_zeros, sat(k + 1));
        end
        idle(2);
        check("R8 idle keeps data", data_zeros, sat(a));
        for (int k = 0; k < b; k++) begin
          put(8'hFE, 1'b1, 1'b0);
          check("R3 code saturation", ecc_zeros, sat(k + 1));
        end
        put(8'hFF, 1'b1, 1'b1);
        verdict("grid", sat(a), sat(b));
        idle(2);
        check("R8 idle keeps verdict", erased, (sat(a) + sat(b)) <= LIM);
      end
    end

    // ordering
    put(8'h00, 1'b1, 1'b0);
    check("R10 code first", order_err, 1);
    put(8'hFF, 1'b0, 1'b0);
    put(8'hFF, 1'b1, 1'b1);
    check("R10 held to end", order_err, 1);
    put(8'hFF, 1'b0, 1'b0);
    check("R10 cleared on new sector", order_err, 0);
    put(8'hFF, 1'b1, 1'b0);
    check("R10 normal order", order_err, 0);
    put(8'hFF, 1'b0, 1'b0);
    check("R10 data after code", order_err, 1);
    put(8'hFF, 1'b1, 1'b1);
    check("R10 still set", order_err, 1);

    // single-byte sector right after another sector
    put(8'h7F, 1'b0, 1'b1);
    verdict("R9 single", 1, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule